// File: doc/BRIEF.md
# Flash Program/Erase Polling Status Generator

This block produces the status a host sees when it reads a flash device while an embedded program or erase operation is running. A one-cycle `wr_done` pulse marks the rising edge of the last write strobe of a command sequence. It carries the kind of operation, the datum, the target address and whether the target sector is write-protected. The block enters the matching busy phase. Every read strobe then returns a polling bit, a status flag, an error flag and an address-match flag. A ready/busy level follows the phase without waiting for a read.

The flash cell timing is modelled by down-counters: `PROG_CYCLES` for a program, `ERASE_CYCLES` for an erase, and a short protected-sector delay derived from `CLK_MHZ` and `PROT_NS`. A `stall` input freezes progress, as if a cell would not converge. If a stall lasts more than `STALL_LIMIT` consecutive busy cycles, the error flag is set and stays set until a clear command.

Erase may be suspended and resumed. While an erase is suspended, unprotected programs may run, and the erase keeps its remaining time across the suspension.

Top module: `poll_status_gen`

## Requirements
- R1: After reset, `ready` is 1 and `rd_valid` is 0. The first read returns `rd_status`=0, `rd_poll`=1 and `rd_err`=0, and the latched address is 0.
- R2: A program accepted from the array-read phase gives a busy phase of `PROG_CYCLES`+1 cycles. During it, reads return `rd_status`=1 and `rd_poll` equal to the inverse of bit `POLL_BIT` of the datum, and `ready` is 0.
- R3: When a program completes, reads return `rd_status`=0 and `rd_poll` equal to the true datum bit `POLL_BIT`, and `ready` is 1.
- R4: An accepted erase gives `ERASE_CYCLES`+1 busy cycles in which `rd_poll`=0 and `ready`=0. After it, reads return `rd_status`=0 and `rd_poll`=1.
- R5: A `suspend_cmd` during an erase leads to the suspended phase: `rd_status`=1, `rd_poll`=1, `ready`=1, and the remaining erase time is frozen. `resume_cmd` continues the erase with that remaining time. Suspend and resume have no effect in the array-read phase.
- R6: A program accepted while the erase is suspended reports busy exactly as in R2, for `PROG_CYCLES`+1 cycles, and then returns to the suspended phase. The erase is still suspended at that point.
- R7: A program aimed at a protected sector from the array-read phase shows busy polling (inverted datum bit, `ready`=0) for `CLK_MHZ`*`PROT_NS`/1000+1 cycles. It then returns to array read with `rd_poll` unchanged from before. A protected program issued while the erase is suspended is ignored.
- R8: If `stall` is held for `STALL_LIMIT`+1 consecutive cycles of a program or erase busy phase, the block enters the fault phase. In that phase `rd_err`=1, `rd_status`=1, `ready`=0, and `rd_poll` holds the operation's busy value. The fault phase ends only on `clear_cmd`, which returns the block to array read.
- R9: A stall no longer than `STALL_LIMIT` cycles causes no error. It lengthens the busy phase by the number of stalled cycles.
- R10: `rd_hit` is 1 exactly when `rd_addr` equals the address latched by the last accepted command. `rd_poll` does not depend on `rd_addr`.
- R11: A `wr_done` arriving during a busy phase is ignored. The busy length and the latched address are unchanged.
- R12: The read outputs update on the clock edge that samples `rd_en`=1 and reflect the phase before that edge. A cycle without `rd_en` gives `rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_done | input | 1 | Pulse: final write strobe of a command sequence |
| wr_op | input | 1 | 0 = program, 1 = erase |
| wr_data | input | DATA_W | Datum being programmed |
| wr_addr | input | ADDR_W | Program address or sector address |
| wr_prot | input | 1 | Target sector is protected |
| suspend_cmd | input | 1 | Erase suspend command pulse |
| resume_cmd | input | 1 | Erase resume command pulse |
| clear_cmd | input | 1 | Reset command pulse, leaves the fault phase |
| stall | input | 1 | Embedded operation cannot progress this cycle |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read result valid this cycle |
| rd_status | output | 1 | 1 = status output, 0 = array read |
| rd_poll | output | 1 | Polling bit |
| rd_err | output | 1 | Error (timeout) flag |
| rd_hit | output | 1 | Read address equals latched command address |
| ready | output | 1 | 1 = ready or erase suspended, 0 = busy or fault |

## Verification
The properties assume that `wr_done`, `suspend_cmd`, `resume_cmd` and `clear_cmd` arrive as single-cycle pulses. They also assume that a suspend never coincides with the last erase cycle, because completion takes priority there. The stimulus applies every command for exactly one cycle. It places suspends only at erase cycle counts from 1 to `ERASE_CYCLES`, so the counter is never at zero when a suspend arrives. Stalls are raised only inside program or erase phases, either shorter than the limit or held past it into the fault phase.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [2:0] {
        ST_ARRAY = 3'd0,
        ST_PROG  = 3'd1,
        ST_ERASE = 3'd2,
        ST_ESUSP = 3'd3,
        ST_PSUSP = 3'd4,
        ST_PROT  = 3'd5,
        ST_FAULT = 3'd6
    } poll_state_e;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } poll_op_e;

    typedef struct packed {
        logic status;
        logic poll;
        logic err;
        logic ready;
    } poll_view_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic state_ready(input poll_state_e s);
        return (s == ST_ARRAY) || (s == ST_ESUSP);
    endfunction

    function automatic logic busy_poll(input poll_op_e op, input logic dbit);
        return (op == OP_ERASE) ? 1'b0 : ~dbit;
    endfunction

endpackage

// File: rtl/poll_countdown.sv
module poll_countdown #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R5: a timer that is neither loaded nor stepped keeps its value (suspend freeze)
    a_r5_cnt_frozen: assert property (@(posedge clk) disable iff (rst)
        (!load && !dec) |=> $stable(cnt));

    // R9: the count never wraps below zero
    a_r9_floor_holds: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero);

endmodule

// File: rtl/poll_sequencer.sv
module poll_sequencer
    import flash_poll_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 8,
    parameter int POLL_BIT     = 7,
    parameter int PROG_CYCLES  = 6,
    parameter int ERASE_CYCLES = 20,
    parameter int PROT_CYCLES  = 10,
    parameter int STALL_LIMIT  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_done,
    input  logic              wr_op,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_prot,
    input  logic              suspend_cmd,
    input  logic              resume_cmd,
    input  logic              clear_cmd,
    input  logic              stall,
    output poll_view_t        view,
    output logic [ADDR_W-1:0] lat_addr
);
    localparam int unsigned MAXC = max3(max3(PROG_CYCLES, ERASE_CYCLES, PROT_CYCLES),
                                        STALL_LIMIT, 1);
    localparam int CW      = $clog2(MAXC + 1);
    localparam int T_PROG  = 0;
    localparam int T_ERASE = 1;
    localparam int T_WD    = 2;
    localparam int NT      = 3;

    poll_state_e state, state_nx;
    poll_op_e    op_q;
    logic        dbit_q, last_q;
    logic        accept_prog, accept_erase, stallable, wd_fire;
    logic [NT-1:0] t_load, t_dec, t_zero;
    logic [CW-1:0] t_val [NT];
    logic          unused_data;

    assign unused_data = ^wr_data;

    always_comb begin
        accept_prog  = wr_done && (wr_op == OP_PROG) &&
                       ((state == ST_ARRAY) ||
                        (state == ST_ESUSP && !resume_cmd && !wr_prot));
        accept_erase = wr_done && (wr_op == OP_ERASE) && (state == ST_ARRAY);
        stallable    = (state == ST_PROG) || (state == ST_PSUSP) || (state == ST_ERASE);
        wd_fire      = stallable && stall && t_zero[T_WD];

        t_load[T_PROG]  = accept_prog;
        t_val[T_PROG]   = (state == ST_ARRAY && wr_prot) ? CW'(PROT_CYCLES) : CW'(PROG_CYCLES);
        t_dec[T_PROG]   = (((state == ST_PROG) || (state == ST_PSUSP)) && !stall) ||
                          (state == ST_PROT);
        t_load[T_ERASE] = accept_erase;
        t_val[T_ERASE]  = CW'(ERASE_CYCLES);
        t_dec[T_ERASE]  = (state == ST_ERASE) && !stall;
        t_load[T_WD]    = !(stallable && stall);
        t_val[T_WD]     = CW'(STALL_LIMIT);
        t_dec[T_WD]     = stallable && stall;
    end

    for (genvar g = 0; g < NT; g++) begin : g_timer
        poll_countdown #(.W(CW)) u_cd (
            .clk      (clk),
            .rst      (rst),
            .load     (t_load[g]),
            .load_val (t_val[g]),
            .dec      (t_dec[g]),
            .zero     (t_zero[g])
        );
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ARRAY: begin
                if (accept_prog)       state_nx = wr_prot ? ST_PROT : ST_PROG;
                else if (accept_erase) state_nx = ST_ERASE;
            end
            ST_PROG: begin
                if (t_zero[T_PROG]) state_nx = ST_ARRAY;
                else if (wd_fire)   state_nx = ST_FAULT;
            end
            ST_PSUSP: begin
                if (t_zero[T_PROG]) state_nx = ST_ESUSP;
                else if (wd_fire)   state_nx = ST_FAULT;
            end
            ST_PROT: begin
                if (t_zero[T_PROG]) state_nx = ST_ARRAY;
            end
            ST_ERASE: begin
                if (t_zero[T_ERASE]) state_nx = ST_ARRAY;
                else if (wd_fire)    state_nx = ST_FAULT;
                else if (suspend_cmd) state_nx = ST_ESUSP;
            end
            ST_ESUSP: begin
                if (resume_cmd)       state_nx = ST_ERASE;
                else if (accept_prog) state_nx = ST_PSUSP;
            end
            ST_FAULT: begin
                if (clear_cmd) state_nx = ST_ARRAY;
            end
            default: state_nx = ST_ARRAY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_ARRAY;
            op_q     <= OP_PROG;
            dbit_q   <= 1'b0;
            last_q   <= 1'b1;
            lat_addr <= '0;
        end else begin
            state <= state_nx;
            if (accept_prog) begin
                dbit_q   <= wr_data[POLL_BIT];
                lat_addr <= wr_addr;
                op_q     <= OP_PROG;
            end
            if (accept_erase) begin
                lat_addr <= wr_addr;
                op_q     <= OP_ERASE;
            end
            if (state == ST_ESUSP && resume_cmd)
                op_q <= OP_ERASE;
            if ((state == ST_PROG || state == ST_PSUSP) && t_zero[T_PROG])
                last_q <= dbit_q;
            if (state == ST_ERASE && t_zero[T_ERASE])
                last_q <= 1'b1;
        end
    end

    always_comb begin
        view.status = (state != ST_ARRAY);
        view.err    = (state == ST_FAULT);
        view.ready  = state_ready(state);
        unique case (state)
            ST_ARRAY:                   view.poll = last_q;
            ST_PROG, ST_PSUSP, ST_PROT: view.poll = ~dbit_q;
            ST_ERASE:                   view.poll = 1'b0;
            ST_ESUSP:                   view.poll = 1'b1;
            ST_FAULT:                   view.poll = busy_poll(op_q, dbit_q);
            default:                    view.poll = last_q;
        endcase
    end

    // R2: an accepted program reports busy with the inverted datum bit on the next cycle
    a_r2_prog_entry: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARRAY && wr_done && wr_op == OP_PROG) |=>
        (view.status && !view.ready && view.poll == !$past(wr_data[POLL_BIT])));

    // R5: a suspend accepted during erase gives ready and a polling bit of 1
    a_r5_suspend_ready: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ERASE && suspend_cmd && !t_zero[T_ERASE] && !wd_fire) |=>
        (view.ready && view.poll && view.status));

    // R7: the end of a protected-sector program leaves the array bit untouched
    a_r7_prot_no_change: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROT && t_zero[T_PROG]) |=> (view.poll == $past(last_q) && view.ready));

    // R8: the error flag is sticky until the clear command
    a_r8_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        (view.err && !clear_cmd) |=> view.err);

    // R11: a command strobe during a busy phase does not move the latched address
    a_r11_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_PROG || state == ST_ERASE || state == ST_PROT) && wr_done) |=>
        $stable(lat_addr));

endmodule

// File: rtl/poll_read_port.sv
module poll_read_port
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] lat_addr,
    input  poll_view_t        view,
    output logic              rd_valid,
    output logic              rd_status,
    output logic              rd_poll,
    output logic              rd_err,
    output logic              rd_hit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            rd_status <= 1'b0;
            rd_poll   <= 1'b0;
            rd_err    <= 1'b0;
            rd_hit    <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_status <= view.status;
                rd_poll   <= view.poll;
                rd_err    <= view.err;
                rd_hit    <= (rd_addr == lat_addr);
            end
        end
    end

    // R12: every read strobe produces a valid result on the following cycle
    a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R12: no strobe, no valid result
    a_r12_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

endmodule

// File: rtl/poll_status_gen.sv
module poll_status_gen
    import flash_poll_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 8,
    parameter int POLL_BIT     = 7,
    parameter int PROG_CYCLES  = 6,
    parameter int ERASE_CYCLES = 20,
    parameter int CLK_MHZ      = 250,
    parameter int PROT_NS      = 40,
    parameter int STALL_LIMIT  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_done,
    input  logic              wr_op,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_prot,
    input  logic              suspend_cmd,
    input  logic              resume_cmd,
    input  logic              clear_cmd,
    input  logic              stall,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic              rd_status,
    output logic              rd_poll,
    output logic              rd_err,
    output logic              rd_hit,
    output logic              ready
);
    localparam int PROT_RAW    = (CLK_MHZ * PROT_NS) / 1000;
    localparam int PROT_CYCLES = (PROT_RAW < 1) ? 1 : PROT_RAW;

    poll_view_t        view;
    logic [ADDR_W-1:0] lat_addr;

    poll_sequencer #(
        .DATA_W       (DATA_W),
        .ADDR_W       (ADDR_W),
        .POLL_BIT     (POLL_BIT),
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES),
        .PROT_CYCLES  (PROT_CYCLES),
        .STALL_LIMIT  (STALL_LIMIT)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .wr_done     (wr_done),
        .wr_op       (wr_op),
        .wr_data     (wr_data),
        .wr_addr     (wr_addr),
        .wr_prot     (wr_prot),
        .suspend_cmd (suspend_cmd),
        .resume_cmd  (resume_cmd),
        .clear_cmd   (clear_cmd),
        .stall       (stall),
        .view        (view),
        .lat_addr    (lat_addr)
    );

    poll_read_port #(.ADDR_W(ADDR_W)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .lat_addr  (lat_addr),
        .view      (view),
        .rd_valid  (rd_valid),
        .rd_status (rd_status),
        .rd_poll   (rd_poll),
        .rd_err    (rd_err),
        .rd_hit    (rd_hit)
    );

    assign ready = view.ready;

endmodule

// File: tb/tb_poll_status_gen.sv
`timescale 1ns/1ps
module tb_poll_status_gen;

    localparam int PROG  = 6;
    localparam int ERASE = 20;
    localparam int PROT  = 10;   // 250 MHz * 40 ns
    localparam int LIM   = 12;

    logic clk = 1'b0;
    logic rst, wr_done, wr_op, wr_prot, suspend_cmd, resume_cmd, clear_cmd, stall, rd_en;
    logic [7:0] wr_data, wr_addr, rd_addr;
    logic rd_valid, rd_status, rd_poll, rd_err, rd_hit, ready;

    int n_chk  = 0;
    int n_fail = 0;
    logic       exp_last = 1'b1;
    logic [7:0] lat_tb   = 8'h00;

    always #2 clk = ~clk;

    poll_status_gen #(
        .DATA_W(8), .ADDR_W(8), .POLL_BIT(7), .PROG_CYCLES(PROG),
        .ERASE_CYCLES(ERASE), .CLK_MHZ(250), .PROT_NS(40), .STALL_LIMIT(LIM)
    ) dut (
        .clk(clk), .rst(rst), .wr_done(wr_done), .wr_op(wr_op), .wr_data(wr_data),
        .wr_addr(wr_addr), .wr_prot(wr_prot), .suspend_cmd(suspend_cmd),
        .resume_cmd(resume_cmd), .clear_cmd(clear_cmd), .stall(stall), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_status(rd_status), .rd_poll(rd_poll),
        .rd_err(rd_err), .rd_hit(rd_hit), .ready(ready)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One phase cycle: ready reflects the phase now, the read result shows it after the edge.
    task automatic cyc(input string req, input logic est, input logic epoll,
                       input logic erdy, input logic eerr);
        logic       cap_en;
        logic [7:0] cap_a;
        chk(req, "ready", ready, erdy);
        cap_en = rd_en;
        cap_a  = rd_addr;
        @(negedge clk);
        if (cap_en) begin
            chk(req, "valid", rd_valid, 1);
            chk(req, "status", rd_status, est);
            chk(req, "poll", rd_poll, epoll);
            chk(req, "err", rd_err, eerr);
            chk("R10", "hit", rd_hit, cap_a == lat_tb);
        end else begin
            chk("R12", "valid-idle", rd_valid, 0);
        end
    endtask

    task automatic do_prog(input logic [7:0] d, input logic [7:0] a);
        wr_done = 1; wr_op = 0; wr_data = d; wr_addr = a; wr_prot = 0;
        cyc("R3", 0, exp_last, 1, 0);
        wr_done = 0; lat_tb = a;
        for (int j = 0; j <= PROG; j++) begin
            rd_addr = a ^ 8'(j);
            cyc("R2", 1, ~d[7], 0, 0);
        end
        rd_addr = a; exp_last = d[7];
        cyc("R3", 0, d[7], 1, 0);
    endtask

    task automatic do_erase_susp(input int k, input logic [7:0] a, input bit with_prog,
                                 input logic [7:0] d);
        wr_done = 1; wr_op = 1; wr_addr = a; wr_prot = 0;
        cyc("R4", 0, exp_last, 1, 0);
        wr_done = 0; lat_tb = a; rd_addr = a;
        for (int j = 0; j < k; j++) begin
            if (j == k - 1) suspend_cmd = 1;
            cyc("R4", 1, 0, 0, 0);
        end
        suspend_cmd = 0;
        cyc("R5", 1, 1, 1, 0);
        if (with_prog) begin
            wr_done = 1; wr_op = 0; wr_data = d; wr_addr = a + 8'd1;
            cyc("R5", 1, 1, 1, 0);
            wr_done = 0; lat_tb = a + 8'd1;
            for (int j = 0; j <= PROG; j++) cyc("R6", 1, ~d[7], 0, 0);
            exp_last = d[7];
            cyc("R6", 1, 1, 1, 0);
        end
        resume_cmd = 1;
        cyc("R5", 1, 1, 1, 0);
        resume_cmd = 0;
        for (int j = 0; j < ERASE + 1 - k; j++) cyc("R5", 1, 0, 0, 0);
        exp_last = 1;
        cyc("R4", 0, 1, 1, 0);
    endtask

    initial begin
        rst = 1; wr_done = 0; wr_op = 0; wr_prot = 0; suspend_cmd = 0; resume_cmd = 0;
        clear_cmd = 0; stall = 0; rd_en = 0; wr_data = 0; wr_addr = 0; rd_addr = 0;
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 0;
                // R1 reset state
                chk("R1", "ready", ready, 1);
                chk("R1", "valid", rd_valid, 0);
                cyc("R1", 0, 1, 1, 0);
                rd_en = 1;
                cyc("R1", 0, 1, 1, 0);

                // R2/R3/R10: sweep of every datum value
                for (int d = 0; d < 256; d++) do_prog(8'(d), 8'(d) ^ 8'h5A);

                // R12: a gap in the read strobe
                rd_en = 0;
                cyc("R12", 0, exp_last, 1, 0);
                rd_en = 1;

                // R5: suspend/resume ignored in array read
                suspend_cmd = 1; cyc("R5", 0, exp_last, 1, 0); suspend_cmd = 0;
                resume_cmd = 1;  cyc("R5", 0, exp_last, 1, 0); resume_cmd = 0;
                cyc("R5", 0, exp_last, 1, 0);

                // R4/R5/R6: erase suspended after every possible count
                for (int k = 1; k <= ERASE; k++)
                    do_erase_susp(k, 8'(k * 3), (k % 2) == 1, 8'(k * 37));

                // R7: protected program from array read, datum chosen to differ
                do_prog(8'h00, 8'h10);
                wr_done = 1; wr_op = 0; wr_data = 8'h80; wr_addr = 8'h20; wr_prot = 1;
                cyc("R7", 0, exp_last, 1, 0);
                wr_done = 0; wr_prot = 0; lat_tb = 8'h20; rd_addr = 8'h20;
                for (int j = 0; j <= PROT; j++) cyc("R7", 1, 1'b0, 0, 0);
                cyc("R7", 0, exp_last, 1, 0);

                // R7: protected program during suspend is ignored
                wr_done = 1; wr_op = 1; wr_addr = 8'h30;
                cyc("R4", 0, exp_last, 1, 0);
                wr_done = 0; lat_tb = 8'h30; rd_addr = 8'h30;
                cyc("R4", 1, 0, 0, 0); cyc("R4", 1, 0, 0, 0);
                suspend_cmd = 1; cyc("R4", 1, 0, 0, 0); suspend_cmd = 0;
                wr_done = 1; wr_op = 0; wr_data = 8'h00; wr_addr = 8'h31; wr_prot = 1;
                cyc("R7", 1, 1, 1, 0);
                wr_done = 0; wr_prot = 0;
                cyc("R7", 1, 1, 1, 0);
                resume_cmd = 1; cyc("R5", 1, 1, 1, 0); resume_cmd = 0;
                for (int j = 0; j < ERASE + 1 - 3; j++) cyc("R5", 1, 0, 0, 0);
                exp_last = 1;
                cyc("R4", 0, 1, 1, 0);

                // R11: a second command during a program is ignored
                wr_done = 1; wr_op = 0; wr_data = 8'h00; wr_addr = 8'h44;
                cyc("R11", 0, exp_last, 1, 0);
                wr_done = 0; lat_tb = 8'h44; rd_addr = 8'h44;
                for (int j = 0; j <= PROG; j++) begin
                    if (j == 2) begin wr_done = 1; wr_op = 1; wr_addr = 8'h99; end
                    cyc("R11", 1, 1, 0, 0);
                    wr_done = 0;
                end
                exp_last = 0;
                cyc("R11", 0, 0, 1, 0);

                // R9: stall just below the limit stretches the program
                wr_done = 1; wr_op = 0; wr_data = 8'h80; wr_addr = 8'h50;
                cyc("R9", 0, exp_last, 1, 0);
                wr_done = 0; lat_tb = 8'h50; rd_addr = 8'h50; stall = 1;
                for (int j = 0; j < LIM + PROG + 1; j++) begin
                    if (j == LIM) stall = 0;
                    cyc("R9", 1, 0, 0, 0);
                end
                exp_last = 1;
                cyc("R9", 0, 1, 1, 0);

                // R8: program timeout
                wr_done = 1; wr_op = 0; wr_data = 8'h00; wr_addr = 8'h60;
                cyc("R8", 0, exp_last, 1, 0);
                wr_done = 0; lat_tb = 8'h60; rd_addr = 8'h60; stall = 1;
                for (int j = 0; j <= LIM; j++) cyc("R8", 1, 1, 0, 0);
                for (int j = 0; j < 4; j++) begin
                    if (j == 2) stall = 0;
                    cyc("R8", 1, 1, 0, 1);
                end
                clear_cmd = 1; cyc("R8", 1, 1, 0, 1); clear_cmd = 0;
                cyc("R8", 0, exp_last, 1, 0);

                // R8: erase timeout
                wr_done = 1; wr_op = 1; wr_addr = 8'h70;
                cyc("R8", 0, exp_last, 1, 0);
                wr_done = 0; lat_tb = 8'h70; rd_addr = 8'h70; stall = 1;
                for (int j = 0; j <= LIM; j++) cyc("R8", 1, 0, 0, 0);
                stall = 0;
                cyc("R8", 1, 0, 0, 1); cyc("R8", 1, 0, 0, 1);
                clear_cmd = 1; cyc("R8", 1, 0, 0, 1); clear_cmd = 0;
                cyc("R8", 0, exp_last, 1, 0);
            end
            begin
                repeat (150000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule